// File: doc/BRIEF.md
# LPC I/O Target

This block is the device side of a low-pin-count I/O cycle. It samples the host's frame strobe and the four-bit multiplexed bus on every clock. It recognises a standard start followed by an I/O cycle type, then collects the 16-bit port address. When the address falls inside a configurable aligned window, it raises a one-clock read or write strobe toward a register file and reports the register's latency on the bus as SYNC wait nibbles. It then drives the ready or error code and, for reads, the data byte. It finishes with one clock of all-ones and then releases the bus.

Cycles that miss the window, cycles of any type other than I/O, and frames whose final start nibble is non-zero are followed only until the host's next frame and are never driven. When the frame strobe drops in the middle of a cycle, the target discards the cycle, releases the bus by the next clock and decodes a new start. The bus itself is outside the block: `lad_o` and `lad_oe_o` feed an external tri-state buffer with a pull-up, and the resolved bus value returns on `lad_i`.

Top module: `lpc_io_target`

## Requirements
- R1: A cycle starts only when the last clock with `lframe_ni` low carries LAD = 0000. The next clock carries the cycle-type nibble, in which bits [3:2] = 00 mark an I/O cycle and bit 1 selects write (1) or read (0). Any other start nibble or type makes the target ignore the cycle.
- R2: The 16-bit address arrives over the four clocks after the type nibble, most significant nibble first. It hits when IO_BASE <= address < IO_BASE + IO_SPAN, and `reg_addr_o` then carries address - IO_BASE.
- R3: On a write hit, two data nibbles follow the address, low nibble first. `reg_wr_o` pulses for exactly one clock, with `reg_wdata_o` valid, in the first clock after the second data nibble.
- R4: On a read hit, `reg_rd_o` pulses for exactly one clock, in the first clock after the last address nibble.
- R5: The target drives SYNC starting two clocks after the strobe. If `reg_ready_i` is first high k clocks after the strobe clock (k = 0 means the same clock), the target drives max(0, k-1) nibbles of 0110 and then 0000.
- R6: If `reg_err_i` is high together with `reg_ready_i`, the final SYNC nibble is 1010. If the register side does not answer within MAX_WAIT wait nibbles, the target drives exactly MAX_WAIT nibbles of 0110 and then 1010.
- R7: On a read, the byte follows in the two clocks after the final SYNC, low nibble first. After a timeout, the byte is 0xFF.
- R8: After the last SYNC or data nibble, the target drives 1111 for one clock and then releases LAD. LAD is also released out of reset.
- R9: A cycle that misses the window, or that is not an I/O cycle, produces no strobe and never enables the LAD driver.
- R10: When `lframe_ni` is low at a clock edge, the LAD driver is off in the following clock and the current cycle is dropped. A new start decoded afterwards is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lframe_ni | input | 1 | Host frame strobe, active low |
| lad_i | input | 4 | Resolved LAD bus value |
| lad_o | output | 4 | Nibble driven by the target |
| lad_oe_o | output | 1 | LAD driver enable |
| reg_addr_o | output | OFF_W = $clog2(IO_SPAN) | Offset of the access within the window |
| reg_wdata_o | output | 8 | Write data byte |
| reg_wr_o | output | 1 | One-clock write strobe |
| reg_rd_o | output | 1 | One-clock read strobe |
| reg_rdata_i | input | 8 | Read data, captured with ready |
| reg_ready_i | input | 1 | Register side has completed the access |
| reg_err_i | input | 1 | Access failed, sampled with ready |

## Verification
Hits at both window edges are driven against misses one below and one past the window. This separates a correct bound comparison from off-by-one decoding and from a wrong offset. Register latencies of zero, one, two and three clocks, together with a register side that never answers, separate correct wait-nibble counting from a missing or extra wait state and confirm that the timeout lands exactly on MAX_WAIT. Memory-type cycles, non-zero start codes, and frames that are long or end on a non-zero nibble check that only the final start nibble decides. Aborts in the address phase and in the SYNC phase show that the target releases the bus at once and recovers for the next cycle.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FRAME, ST_ADDR, ST_WDATA, ST_TAR_IN,
    ST_SYNC, ST_RDATA, ST_TAR_OUT, ST_SKIP
  } state_t;

  localparam logic [3:0] START_ISA  = 4'b0000;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_WAIT  = 4'b0110;
  localparam logic [3:0] SYNC_ERR   = 4'b1010;
  localparam logic [3:0] TURN_NIB   = 4'b1111;
  localparam logic [1:0] CT_IO      = 2'b00;
endpackage

// File: rtl/lpc_io_addr_match.sv
module lpc_io_addr_match #(
  parameter logic [15:0] IO_BASE = 16'h02E8,
  parameter int unsigned OFF_W   = 3
) (
  input  logic [15:0]      addr_i,
  output logic             hit_o,
  output logic [OFF_W-1:0] offset_o
);
  // window is aligned to its size, so the offset is the low address bits
  generate
    if (OFF_W >= 16) begin : g_full
      assign hit_o = 1'b1;
    end else begin : g_cmp
      assign hit_o = (addr_i[15:OFF_W] == IO_BASE[15:OFF_W]);
    end
  endgenerate

  assign offset_o = addr_i[OFF_W-1:0];
endmodule

// File: rtl/lpc_io_wait_timer.sv
module lpc_io_wait_timer #(
  parameter int unsigned MAX_WAIT = 8,
  localparam int unsigned CW = $clog2(MAX_WAIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(MAX_WAIT));

  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_WAIT)); // R6
  AST_EXPIRED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> expired_o); // R6
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_io_pkg::*;
#(
  parameter logic [15:0] IO_BASE  = 16'h02E8,
  parameter int unsigned IO_SPAN  = 8,
  parameter int unsigned MAX_WAIT = 8,
  localparam int unsigned OFF_W   = $clog2(IO_SPAN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lframe_ni,
  input  logic [3:0]       lad_i,
  output logic [3:0]       lad_o,
  output logic             lad_oe_o,
  output logic [OFF_W-1:0] reg_addr_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_wr_o,
  output logic             reg_rd_o,
  input  logic [7:0]       reg_rdata_i,
  input  logic             reg_ready_i,
  input  logic             reg_err_i
);
  state_t           state_q;
  logic [1:0]       nib_q;
  logic             start_ok_q, is_wr_q, done_q, err_q;
  logic [15:0]      addr_q;
  logic [OFF_W-1:0] off_q;
  logic [7:0]       wdata_q, rdata_q;

  logic [15:0]      addr_nx;
  logic             hit;
  logic [OFF_W-1:0] off_nx;
  logic             expired, in_wait;
  logic [3:0]       sync_nib;

  assign addr_nx = {addr_q[11:0], lad_i};

  lpc_io_addr_match #(.IO_BASE(IO_BASE), .OFF_W(OFF_W)) u_match (
    .addr_i   (addr_nx),
    .hit_o    (hit),
    .offset_o (off_nx)
  );

  lpc_io_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q != ST_SYNC),
    .step_i    ((state_q == ST_SYNC) && !done_q),
    .expired_o (expired)
  );

  assign in_wait  = (state_q == ST_TAR_IN) || (state_q == ST_SYNC);
  assign sync_nib = done_q  ? (err_q ? SYNC_ERR : SYNC_READY)
                  : expired ? SYNC_ERR : SYNC_WAIT;

  always_comb begin
    lad_oe_o = 1'b0;
    lad_o    = TURN_NIB;
    unique case (state_q)
      ST_SYNC: begin
        lad_oe_o = 1'b1;
        lad_o    = sync_nib;
      end
      ST_RDATA: begin
        lad_oe_o = 1'b1;
        lad_o    = nib_q[0] ? rdata_q[7:4] : rdata_q[3:0];
      end
      ST_TAR_OUT: lad_oe_o = (nib_q == 2'd0);
      default: ;
    endcase
  end

  assign reg_wr_o    = (state_q == ST_TAR_IN) && (nib_q == 2'd0) && is_wr_q;
  assign reg_rd_o    = (state_q == ST_TAR_IN) && (nib_q == 2'd0) && !is_wr_q;
  assign reg_addr_o  = off_q;
  assign reg_wdata_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      nib_q      <= '0;
      start_ok_q <= 1'b0;
      is_wr_q    <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      addr_q     <= '0;
      off_q      <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
    end else if (!lframe_ni) begin
      // any low frame restarts decoding; only the last start nibble counts
      state_q    <= ST_FRAME;
      start_ok_q <= (lad_i == START_ISA);
      done_q     <= 1'b0;
    end else begin
      if (in_wait && !done_q && !expired && reg_ready_i) begin
        done_q  <= 1'b1;
        err_q   <= reg_err_i;
        rdata_q <= reg_rdata_i;
      end
      unique case (state_q)
        ST_IDLE, ST_SKIP: ;
        ST_FRAME: begin
          nib_q <= '0;
          if (start_ok_q && lad_i[3:2] == CT_IO) begin
            is_wr_q <= lad_i[1];
            state_q <= ST_ADDR;
          end else begin
            state_q <= ST_SKIP;
          end
        end
        ST_ADDR: begin
          addr_q <= addr_nx;
          nib_q  <= nib_q + 2'd1;
          if (nib_q == 2'd3) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= 8'hFF;
            if (hit) begin
              off_q   <= off_nx;
              state_q <= is_wr_q ? ST_WDATA : ST_TAR_IN;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_WDATA: begin
          nib_q <= nib_q + 2'd1;
          if (nib_q == 2'd0) begin
            wdata_q[3:0] <= lad_i;
          end else begin
            wdata_q[7:4] <= lad_i;
            nib_q        <= '0;
            state_q      <= ST_TAR_IN;
          end
        end
        ST_TAR_IN: begin
          nib_q <= nib_q + 2'd1;
          if (nib_q == 2'd1) begin
            nib_q   <= '0;
            state_q <= ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (done_q || expired) begin
            if (!done_q) begin
              err_q   <= 1'b1;
              rdata_q <= 8'hFF;
            end
            nib_q   <= '0;
            state_q <= is_wr_q ? ST_TAR_OUT : ST_RDATA;
          end
        end
        ST_RDATA: begin
          nib_q <= nib_q + 2'd1;
          if (nib_q == 2'd1) begin
            nib_q   <= '0;
            state_q <= ST_TAR_OUT;
          end
        end
        ST_TAR_OUT: begin
          nib_q <= nib_q + 2'd1;
          if (nib_q == 2'd1) begin
            nib_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ABORT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_ni |=> !lad_oe_o); // R10
  AST_WR_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o); // R3
  AST_RD_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o); // R4
  AST_FIRST_DRIVE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> (lad_o == SYNC_WAIT || lad_o == SYNC_READY || lad_o == SYNC_ERR)); // R5
  AST_TURN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lad_oe_o && state_q == ST_TAR_OUT) |=> !lad_oe_o); // R8
  AST_DRIVE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o || reg_rd_o) |=> (!lad_oe_o)); // R9
endmodule

// File: tb/lpc_io_target_test.sv
module lpc_io_target_test;
  localparam logic [15:0] BASE = 16'h02E8;
  localparam int SPAN = 8;
  localparam int MAXW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       host_oe = 1'b1;
  logic       lframe_n = 1'b1;
  logic [3:0] host_lad = 4'hF;
  logic [3:0] lad_bus, lad_o;
  logic       lad_oe;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd, reg_err;
  logic       reg_ready = 1'b0;

  assign lad_bus = lad_oe ? lad_o : (host_oe ? host_lad : 4'hF);

  int   n_run = 0, n_fail = 0;
  int   rsp_lat = 0, rsp_cnt = 0, strb_cnt = 0;
  bit   rsp_pend = 0, s_wr = 0, rsp_err_v = 0;
  logic [7:0] rsp_data = 8'h00, s_wd = 8'h00;
  logic [2:0] s_addr = 3'd0;

  assign reg_rdata = rsp_data;
  assign reg_err   = rsp_err_v;

  lpc_io_target #(.IO_BASE(BASE), .IO_SPAN(SPAN), .MAX_WAIT(MAXW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lframe_ni(lframe_n), .lad_i(lad_bus),
    .lad_o(lad_o), .lad_oe_o(lad_oe), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd),
    .reg_rdata_i(reg_rdata), .reg_ready_i(reg_ready), .reg_err_i(reg_err)
  );

  // register-side model: ready arrives rsp_lat clocks after the strobe clock
  always @(negedge clk) begin
    if (rsp_pend) begin
      if (rsp_cnt == rsp_lat) begin reg_ready <= 1'b1; rsp_pend = 0; end
      else begin reg_ready <= 1'b0; rsp_cnt++; end
    end else begin
      reg_ready <= 1'b0;
    end
    if (reg_wr || reg_rd) begin
      strb_cnt++;
      s_addr = reg_addr;
      s_wd   = reg_wdata;
      s_wr   = reg_wr;
      if (rsp_lat == 0) reg_ready <= 1'b1;
      else begin rsp_pend = 1; rsp_cnt = 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_nib(input logic lf, input logic [3:0] nib);
    lframe_n = lf; host_lad = nib; host_oe = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_release();
    lframe_n = 1'b1; host_oe = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_head(input logic [3:0] st, input logic [3:0] ct, input logic [15:0] a);
    host_nib(1'b0, st);
    host_nib(1'b1, ct);
    for (int i = 0; i < 4; i++) host_nib(1'b1, a[15-4*i -: 4]);
  endtask

  task automatic expect_quiet(input int n, input string req, input string what);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      if (lad_oe) ok = 0;
      @(negedge clk);
    end
    chk(ok, req, what, 1, 0);
  endtask

  task automatic io_cycle(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                          input int lat, input logic [7:0] rd, input bit err,
                          input bit exp_hit, input int exp_waits,
                          input logic [3:0] exp_sync, input logic [7:0] exp_rd,
                          input string sreq);
    int s0, waits;
    string req;
    req = wr ? "R3" : "R4";
    rsp_pend = 0; rsp_lat = lat; rsp_data = rd; rsp_err_v = err;
    s0 = strb_cnt;
    send_head(4'b0000, wr ? 4'b0010 : 4'b0000, a);
    if (wr) begin host_nib(1'b1, wd[3:0]); host_nib(1'b1, wd[7:4]); end
    host_nib(1'b1, 4'hF);
    host_release();
    if (!exp_hit) begin
      expect_quiet(14, "R9", "bus driven on ignored cycle");
      chk(strb_cnt == s0, "R9", "strobe on ignored cycle", strb_cnt - s0, 0);
      return;
    end
    chk(strb_cnt == s0 + 1, req, "strobe count", strb_cnt - s0, 1);
    chk(s_wr == wr, req, "strobe direction", s_wr, wr);
    chk(s_addr == a[2:0], "R2", "register offset", s_addr, a[2:0]);
    if (wr) chk(s_wd == wd, "R3", "write data", s_wd, wd);
    waits = 0;
    while (lad_oe && lad_o == 4'b0110 && waits < 40) begin
      waits++;
      @(negedge clk);
    end
    chk(waits == exp_waits, "R5", "wait nibbles", waits, exp_waits);
    chk(lad_oe && lad_o == exp_sync, sreq, "final sync", {lad_oe, lad_o}, {1'b1, exp_sync});
    @(negedge clk);
    if (!wr) begin
      chk(lad_oe && lad_o == exp_rd[3:0], "R7", "read low nibble", lad_o, exp_rd[3:0]);
      @(negedge clk);
      chk(lad_oe && lad_o == exp_rd[7:4], "R7", "read high nibble", lad_o, exp_rd[7:4]);
      @(negedge clk);
    end
    chk(lad_oe && lad_o == 4'hF, "R8", "turnaround drive", {lad_oe, lad_o}, 5'h1F);
    @(negedge clk);
    chk(!lad_oe, "R8", "release after turnaround", lad_oe, 0);
    @(negedge clk);
    chk(!lad_oe, "R8", "stays released", lad_oe, 0);
  endtask

  task automatic t_reset();
    chk(!lad_oe && !reg_wr && !reg_rd, "R8", "reset outputs", {lad_oe, reg_wr, reg_rd}, 0);
  endtask

  task automatic t_hits();
    io_cycle(1, 16'h02E8, 8'hC3, 0, 8'h00, 0, 1, 0, 4'b0000, 8'h00, "R5");
    io_cycle(0, 16'h02EF, 8'h00, 3, 8'hA5, 0, 1, 2, 4'b0000, 8'hA5, "R5");
    io_cycle(1, 16'h02EA, 8'h3C, 1, 8'h00, 0, 1, 0, 4'b0000, 8'h00, "R5");
  endtask

  task automatic t_errors();
    io_cycle(0, 16'h02EB, 8'h00, 2, 8'h5A, 1, 1, 1, 4'b1010, 8'h5A, "R6");
    io_cycle(0, 16'h02EC, 8'h00, 200, 8'h11, 0, 1, MAXW, 4'b1010, 8'hFF, "R6");
    io_cycle(1, 16'h02ED, 8'h77, 200, 8'h00, 0, 1, MAXW, 4'b1010, 8'h00, "R6");
  endtask

  task automatic t_misses();
    io_cycle(0, 16'h02E7, 8'h00, 0, 8'h00, 0, 0, 0, 4'b0000, 8'h00, "R2");
    io_cycle(1, 16'h02F0, 8'h12, 0, 8'h00, 0, 0, 0, 4'b0000, 8'h00, "R2");
  endtask

  task automatic t_non_io();
    int s0 = strb_cnt;
    host_nib(1'b0, 4'b0000);
    host_nib(1'b1, 4'b0100);  // memory read type
    for (int i = 0; i < 8; i++) host_nib(1'b1, (i == 5) ? 4'h2 : (i == 6) ? 4'hE : (i == 7) ? 4'h8 : 4'h0);
    host_nib(1'b1, 4'hF);
    host_release();
    expect_quiet(12, "R9", "memory cycle driven");
    chk(strb_cnt == s0, "R9", "memory cycle strobe", strb_cnt - s0, 0);
  endtask

  task automatic t_starts();
    int s0 = strb_cnt;
    // non-zero start code
    send_head(4'b0101, 4'b0000, 16'h02E8);
    host_nib(1'b1, 4'hF);
    host_release();
    expect_quiet(12, "R1", "non-zero start driven");
    chk(strb_cnt == s0, "R1", "non-zero start strobe", strb_cnt - s0, 0);
    // long frame whose last nibble is not zero
    host_nib(1'b0, 4'h0);
    send_head(4'hF, 4'b0000, 16'h02E9);
    host_nib(1'b1, 4'hF);
    host_release();
    expect_quiet(12, "R1", "frame ending non-zero driven");
    chk(strb_cnt == s0, "R1", "frame ending non-zero strobe", strb_cnt - s0, 0);
    // long frame ending on zero is a valid start
    host_nib(1'b0, 4'hF);
    host_nib(1'b0, 4'h5);
    io_cycle(0, 16'h02E9, 8'h00, 0, 8'h96, 0, 1, 0, 4'b0000, 8'h96, "R1");
  endtask

  task automatic t_abort_addr();
    host_nib(1'b0, 4'h0);
    host_nib(1'b1, 4'b0010);
    host_nib(1'b1, 4'h0);
    host_nib(1'b1, 4'h2);
    io_cycle(0, 16'h02EE, 8'h00, 1, 8'h4B, 0, 1, 0, 4'b0000, 8'h4B, "R10");
  endtask

  task automatic t_abort_sync();
    rsp_pend = 0; rsp_lat = 200; rsp_err_v = 0;
    send_head(4'b0000, 4'b0010, 16'h02E8);
    host_nib(1'b1, 4'h1);
    host_nib(1'b1, 4'h2);
    host_nib(1'b1, 4'hF);
    host_release();
    chk(lad_oe && lad_o == 4'b0110, "R10", "waiting before abort", {lad_oe, lad_o}, 5'h16);
    host_nib(1'b0, 4'hF);
    chk(!lad_oe, "R10", "released after abort", lad_oe, 0);
    host_nib(1'b0, 4'hF);
    host_nib(1'b0, 4'hF);
    host_nib(1'b0, 4'hF);
    host_release();
    expect_quiet(12, "R10", "driven after abort");
    io_cycle(1, 16'h02EF, 8'hE1, 0, 8'h00, 0, 1, 0, 4'b0000, 8'h00, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    host_oe = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_hits();
    t_errors();
    t_misses();
    t_non_io();
    t_starts();
    t_abort_addr();
    t_abort_sync();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule